// File: doc/BRIEF.md
# Function-Coded Integer ALU

A purely combinational integer arithmetic/logic unit for a datapath. It takes two operands and a three-bit function code and returns one result word, together with a flag that says whether that result is all zeros. All arithmetic functions share a single adder. The upper function bit inverts the second operand and also feeds the adder's carry-in, so the same adder forms either `a + b` or `a + ~b + 1`. The lower two function bits steer a four-way result selector that picks the bitwise AND, the bitwise OR, the adder sum, or the sign of the sum.

The set-less-than result is the most significant bit of the raw difference, zero-extended to the full width. No overflow correction is applied. A caller that needs a signed comparison that is exact across the full range must handle overflow elsewhere. Code `011` carries no function, and the unit drives an all-zero result for it.

Top module: `fn_alu`

## Requirements
- R1: Function code `000` gives `y_o = a_i & b_i`.
- R2: Function code `001` gives `y_o = a_i | b_i`.
- R3: Function code `010` gives `y_o = (a_i + b_i) mod 2^WIDTH`. A carry out of the top bit is dropped.
- R4: Function code `110` gives `y_o = (a_i - b_i) mod 2^WIDTH`, formed as `a_i + ~b_i + 1`.
- R5: Function code `100` gives `y_o = a_i & ~b_i`.
- R6: Function code `101` gives `y_o = a_i | ~b_i`.
- R7: Function code `111` gives `y_o` bit 0 equal to bit WIDTH-1 of `a_i - b_i`, with all other bits zero. There is no overflow correction: for a=25, b=32 the result is 1, and for a=0x80000000, b=1 the result is 0.
- R8: Function code `011` gives `y_o = 0` for any operands.
- R9: `zero_o` is 1 exactly when `y_o` is all zeros, under every function code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand; inverted when fn_i[2] is 1 |
| fn_i | input | 3 | Function code |
| y_o | output | WIDTH | Result word |
| zero_o | output | 1 | High when y_o is all zeros |

## Verification
The bench builds the unit at its default WIDTH of 32. At that width the set-less-than corner cases can be reached directly: the most negative operand minus a positive one, and the largest positive operand minus minus-one. In both cases the raw sign differs from the true signed order. The 32-bit width also exercises the full five-level depth of the prefix carry network. Carry chains that run through every column are reached with all-ones operands, with wraparound to zero, and with equal operands under subtraction, which also drive the zero flag high.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    FN_AND  = 3'b000,
    FN_OR   = 3'b001,
    FN_ADD  = 3'b010,
    FN_NONE = 3'b011,
    FN_ANDN = 3'b100,
    FN_ORN  = 3'b101,
    FN_SUB  = 3'b110,
    FN_SLT  = 3'b111
  } alu_fn_e;

  localparam int unsigned FN_W = 3;
endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] b_o
);
  assign b_o = b_i ^ {WIDTH{inv_i}};
endmodule

// File: rtl/alu_prefix_adder.sv
module alu_prefix_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o
);
  localparam int unsigned LVLS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [WIDTH-1:0] half_sum;
  logic [WIDTH-1:0] gen  [LVLS+1];
  logic [WIDTH-1:0] prop [LVLS+1];
  logic [WIDTH-1:0] carry;

  assign half_sum = a_i ^ b_i;
  // carry-in folded into column 0 so every prefix reaches it
  assign gen[0]  = (a_i & b_i) | {{(WIDTH-1){1'b0}}, half_sum[0] & cin_i};
  assign prop[0] = half_sum;

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    localparam int unsigned SPAN = 1 << l;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i >= SPAN) begin : g_comb
        assign gen[l+1][i]  = gen[l][i] | (prop[l][i] & gen[l][i-SPAN]);
        assign prop[l+1][i] = prop[l][i] & prop[l][i-SPAN];
      end else begin : g_pass
        assign gen[l+1][i]  = gen[l][i];
        assign prop[l+1][i] = prop[l][i];
      end
    end
  end

  assign carry = {gen[LVLS][WIDTH-2:0], cin_i};
  assign sum_o = half_sum ^ carry;
endmodule

// File: rtl/alu_result_sel.sv
module alu_result_sel
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [FN_W-1:0]  fn_i,
  input  logic [WIDTH-1:0] and_i,
  input  logic [WIDTH-1:0] or_i,
  input  logic [WIDTH-1:0] sum_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    unique case (fn_i[1:0])
      2'b00:   y_o = and_i;
      2'b01:   y_o = or_i;
      2'b10:   y_o = sum_i;
      default: y_o = {{(WIDTH-1){1'b0}}, sum_i[WIDTH-1]};
    endcase
    if (alu_fn_e'(fn_i) == FN_NONE) y_o = '0;
  end
endmodule

// File: rtl/fn_alu.sv
module fn_alu
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [FN_W-1:0]  fn_i,
  output logic [WIDTH-1:0] y_o,
  output logic             zero_o
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;

  alu_operand_cond #(.WIDTH(WIDTH)) cond_i (
    .b_i   (b_i),
    .inv_i (fn_i[2]),
    .b_o   (b_eff)
  );

  alu_prefix_adder #(.WIDTH(WIDTH)) add_i (
    .a_i   (a_i),
    .b_i   (b_eff),
    .cin_i (fn_i[2]),
    .sum_o (sum)
  );

  alu_result_sel #(.WIDTH(WIDTH)) sel_i (
    .fn_i  (fn_i),
    .and_i (a_i & b_eff),
    .or_i  (a_i | b_eff),
    .sum_i (sum),
    .y_o   (y_o)
  );

  assign zero_o = ~|y_o;
endmodule

// File: rtl/fn_alu_chk.sv
module fn_alu_chk
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [FN_W-1:0]  fn_i,
  input logic [WIDTH-1:0] y_o,
  input logic             zero_o
);
  always_comb begin
    a_r9_zero_flag: assert (zero_o == (y_o == '0));
    if (fn_i == 3'b011) a_r8_unused_zero: assert (y_o == '0);
    if (fn_i == 3'b111) a_r7_slt_bool: assert (y_o[WIDTH-1:1] == '0);
    if (fn_i == 3'b010) a_r3_add: assert (y_o == a_i + b_i);
    if (fn_i == 3'b110) a_r4_sub: assert (y_o == a_i - b_i);
    if (fn_i == 3'b000) a_r1_and: assert (y_o == (a_i & b_i));
  end
endmodule

bind fn_alu fn_alu_chk #(.WIDTH(WIDTH)) chk_i (
  .a_i    (a_i),
  .b_i    (b_i),
  .fn_i   (fn_i),
  .y_o    (y_o),
  .zero_o (zero_o)
);

// File: tb/fn_alu_tb_top.sv
module fn_alu_tb_top;
  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a, b, y;
  logic [2:0]   fn;
  logic         zero;
  int           checks = 0;
  int           errors = 0;

  always #10 clk = ~clk;

  fn_alu #(.WIDTH(W)) dut_i (
    .a_i(a), .b_i(b), .fn_i(fn), .y_o(y), .zero_o(zero)
  );

  function automatic logic [W-1:0] model(input logic [2:0] f,
                                         input logic [W-1:0] x,
                                         input logic [W-1:0] z);
    logic [W-1:0] d;
    d = x - z;
    case (f)
      3'b000:  return x & z;
      3'b001:  return x | z;
      3'b010:  return x + z;
      3'b100:  return x & ~z;
      3'b101:  return x | ~z;
      3'b110:  return d;
      3'b111:  return {{(W-1){1'b0}}, d[W-1]};
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] f);
    case (f)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b110:  return "R4";
      3'b100:  return "R5";
      3'b101:  return "R6";
      3'b111:  return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input logic [2:0] f, input logic [W-1:0] x,
                       input logic [W-1:0] z);
    logic [W-1:0] exp_y;
    @(negedge clk);
    fn = f; a = x; b = z;
    #5;
    exp_y = model(f, x, z);
    checks++;
    if (y !== exp_y) begin
      errors++;
      $display("FAIL %s fn=%b a=%h b=%h y=%h expected %h",
               req_of(f), f, x, z, y, exp_y);
    end
    checks++;
    if (zero !== (exp_y == '0)) begin
      errors++;
      $display("FAIL R9 fn=%b zero=%b expected %b", f, zero, exp_y == '0);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    fn = '0; a = '0; b = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // reset state: all-zero inputs give a zero result and the flag (R1, R9)
    apply(3'b000, '0, '0);
    // R7 directed: 25 < 32 gives 1; raw sign without overflow correction
    apply(3'b111, 32'd25, 32'd32);
    apply(3'b111, 32'h8000_0000, 32'd1);
    apply(3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    apply(3'b111, 32'd5, 32'd5);
    // R3 wraparound, full carry chain
    apply(3'b010, 32'hFFFF_FFFF, 32'd1);
    apply(3'b010, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    // R4 equal operands and borrow through every bit
    apply(3'b110, 32'h1234_5678, 32'h1234_5678);
    apply(3'b110, 32'd0, 32'd1);
    // R5, R6 with all-ones operand
    apply(3'b100, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    apply(3'b101, 32'd0, 32'd0);
    // R8 unused code with nonzero operands
    apply(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    for (int f = 0; f < 8; f++) begin
      for (int k = 0; k < 300; k++) begin
        logic [W-1:0] ra, rb;
        ra = $urandom;
        rb = (k % 5 == 0) ? ra : $urandom;
        apply(3'(f), ra, rb);
      end
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule